// File: doc/BRIEF.md
# Programmable FIFO Threshold Flags

This block produces the two programmable threshold flags of a dual-clock FIFO with DEPTH words of storage. Both flags are active low. `paf_n` warns that the FIFO is close to full. `pae_n` warns that it is close to empty. Each threshold is set by an offset: a full offset `m` counted down from the top, and an empty offset `n` counted up from zero. The surrounding FIFO supplies its binary write and read transfer counters, one from each clock domain. The block carries each counter into the other domain as a Gray code through a synchronizer chain. It then computes the fill level separately in each domain.

Two bits are captured only while master reset is held. The fall-through bit says that the FIFO holds one extra word in an output stage, so both thresholds move up by one word. The timing bit chooses between two schemes:
- In synchronous timing, each flag is registered in a single clock domain: `paf_n` in the write domain and `pae_n` in the read domain.
- In asynchronous timing, each flag is set by one domain and released by the other. The set and release are carried as a pair of toggle bits, one per domain.

A flag may be released late by the synchronizer latency. It is never set before its own domain sees the threshold.

Top module: `ptf_flags`

## Requirements
- R1: While master reset is low and on its release with both counters at zero, `paf_n` is 1 and `pae_n` is 0.
- R2: In standard mode, once inputs are stable, `paf_n` is 0 exactly when the level (written minus read words, modulo the counter width) is at least DEPTH − m.
- R3: In fall-through mode, once inputs are stable, `paf_n` is 0 exactly when the level is at least DEPTH + 1 − m.
- R4: In standard mode, once inputs are stable, `pae_n` is 0 exactly when the level is at most n.
- R5: In fall-through mode, once inputs are stable, `pae_n` is 0 exactly when the level is at most n + 1.
- R6: In asynchronous timing, a write that brings the level to the full threshold drives `paf_n` low on the next `wclk` rising edge. A read that brings the level below the threshold drives it high on the next `rclk` rising edge.
- R7: In asynchronous timing, a read that brings the level to the empty threshold drives `pae_n` low on the next `rclk` rising edge. A write that lifts the level above it drives `pae_n` high on the next `wclk` rising edge.
- R8: In synchronous timing, `paf_n` changes only at `wclk` edges. A write reaching the threshold sets it on the next `wclk` edge. A read release is not yet visible at the next `rclk` edge, because it waits for the read counter to cross into the write domain.
- R9: In synchronous timing, `pae_n` changes only at `rclk` edges. A read reaching the threshold sets it on the next `rclk` edge. A write release is not yet visible at the next `wclk` edge.
- R10: The timing bit and the fall-through bit are captured only while master reset is low. Changing them afterwards changes neither the thresholds nor the release timing.
- R11: Thresholds stay correct after the transfer counters wrap around their width, and under concurrent reads and writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-domain clock |
| rclk | input | 1 | Read-domain clock |
| mrst_n | input | 1 | Master reset, active low, asynchronous assert |
| async_cfg | input | 1 | 1 = asynchronous flag timing; captured during reset |
| fwft_cfg | input | 1 | 1 = fall-through mode; captured during reset |
| wr_ptr | input | PTR_W | Binary write counter, `wclk` domain, steps by at most 1 per edge |
| rd_ptr | input | PTR_W | Binary read counter, `rclk` domain, steps by at most 1 per edge |
| full_off | input | OFF_W | Full offset m |
| empty_off | input | OFF_W | Empty offset n |
| paf_n | output | 1 | Almost-full flag, active low |
| pae_n | output | 1 | Almost-empty flag, active low |

## Verification
The interesting collision is a flag being set in one clock domain while the other domain is releasing it. This happens when writes and reads arrive together around a threshold. The bench provokes it by running random write and read bursts concurrently, with offsets re-drawn so that the thresholds sit inside the range being swept. After each burst the bench lets both domains settle. It then compares both flags with its own threshold functions of the tracked level, which shows that no toggle pair is left in an inconsistent state. Directed single-word steps across each threshold pin down the edge on which each set and release appears in both timing schemes.

// File: rtl/ptf_pkg.sv
package ptf_pkg;

  // Level at or above which the almost-full condition holds.
  function automatic int full_mark(int depth, int off, logic fwft);
    return depth - off + int'(fwft);
  endfunction

  // Level at or below which the almost-empty condition holds.
  function automatic int empty_mark(int off, logic fwft);
    return off + int'(fwft);
  endfunction

  function automatic logic reach_full(int level, int depth, int off, logic fwft);
    return level >= full_mark(depth, off, fwft);
  endfunction

  function automatic logic reach_empty(int level, int off, logic fwft);
    return level <= empty_mark(off, fwft);
  endfunction

endpackage

// File: rtl/ptf_ptr_xfer.sv
module ptf_ptr_xfer #(
  parameter int PTR_W  = 12,
  parameter int STAGES = 2
) (
  input  logic             src_clk,
  input  logic             dst_clk,
  input  logic             rst_n,
  input  logic [PTR_W-1:0] src_ptr,
  output logic [PTR_W-1:0] dst_ptr
);

  function automatic logic [PTR_W-1:0] to_gray(input logic [PTR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_W-1:0] to_bin(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PTR_W-1:0] gray_src;
  logic [PTR_W-1:0] chain [STAGES];

  // Registered Gray code in the source domain: one bit moves per step.
  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) gray_src <= '0;
    else        gray_src <= to_gray(src_ptr);
  end

  always_ff @(posedge dst_clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= gray_src;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign dst_ptr = to_bin(chain[STAGES-1]);

endmodule

// File: rtl/ptf_side.sv
module ptf_side #(
  parameter int DEPTH      = 1024,
  parameter int PTR_W      = 12,
  parameter int OFF_W      = 10,
  parameter int DEF_OFF    = 127,
  parameter bit WRITE_SIDE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             async_cfg,
  input  logic             fwft_cfg,
  input  logic [PTR_W-1:0] own_ptr,
  input  logic [PTR_W-1:0] far_ptr,
  input  logic [OFF_W-1:0] full_off,
  input  logic [OFF_W-1:0] empty_off,
  output logic             full_hit,
  output logic             empty_hit,
  output logic             async_q
);

  localparam logic [OFF_W-1:0] OFF_RST = OFF_W'(DEF_OFF);

  logic             fwft_q;
  logic [OFF_W-1:0] full_off_q;
  logic [OFF_W-1:0] empty_off_q;
  logic [PTR_W-1:0] level;

  // Mode bits follow their inputs only while reset is held.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      async_q <= async_cfg;
      fwft_q  <= fwft_cfg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_off_q  <= OFF_RST;
      empty_off_q <= OFF_RST;
    end else begin
      full_off_q  <= full_off;
      empty_off_q <= empty_off;
    end
  end

  generate
    if (WRITE_SIDE) begin : g_wr
      assign level = own_ptr - far_ptr;
    end else begin : g_rd
      assign level = far_ptr - own_ptr;
    end
  endgenerate

  assign full_hit  = ptf_pkg::reach_full(int'(level), DEPTH, int'(full_off_q), fwft_q);
  assign empty_hit = ptf_pkg::reach_empty(int'(level), int'(empty_off_q), fwft_q);

endmodule

// File: rtl/ptf_flag_unit.sv
module ptf_flag_unit #(
  parameter bit RST_ASSERTED = 1'b0,
  parameter int STAGES       = 2
) (
  input  logic set_clk,
  input  logic clr_clk,
  input  logic rst_n,
  input  logic async_s,
  input  logic async_c,
  input  logic cond_s,
  input  logic cond_c,
  output logic flag_n
);

  logic              set_tog;
  logic              clr_tog;
  logic              sync_flag_n;
  logic [STAGES-1:0] clr_seen;
  logic [STAGES-1:0] set_seen;
  logic              asserted_s;
  logic              asserted_c;

  assign asserted_s = set_tog ^ clr_seen[STAGES-1];
  assign asserted_c = set_seen[STAGES-1] ^ clr_tog;

  // Set domain: synchronous flag and the set toggle.
  always_ff @(posedge set_clk or negedge rst_n) begin
    if (!rst_n) begin
      set_tog     <= RST_ASSERTED;
      sync_flag_n <= !RST_ASSERTED;
      clr_seen    <= '0;
    end else begin
      clr_seen    <= {clr_seen[STAGES-2:0], clr_tog};
      sync_flag_n <= !cond_s;
      if (async_s && !asserted_s && cond_s) set_tog <= ~set_tog;
    end
  end

  // Clear domain: the release toggle.
  always_ff @(posedge clr_clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_tog  <= 1'b0;
      set_seen <= {STAGES{RST_ASSERTED}};
    end else begin
      set_seen <= {set_seen[STAGES-2:0], set_tog};
      if (async_c && asserted_c && !cond_c) clr_tog <= ~clr_tog;
    end
  end

  assign flag_n = async_s ? ~(set_tog ^ clr_tog) : sync_flag_n;

endmodule

// File: rtl/ptf_flags.sv
module ptf_flags #(
  parameter int DEPTH       = 1024,
  parameter int SYNC_STAGES = 2,
  parameter int DEF_OFF     = 127,
  localparam int OFF_W      = $clog2(DEPTH),
  localparam int PTR_W      = $clog2(DEPTH + 1) + 1
) (
  input  logic             wclk,
  input  logic             rclk,
  input  logic             mrst_n,
  input  logic             async_cfg,
  input  logic             fwft_cfg,
  input  logic [PTR_W-1:0] wr_ptr,
  input  logic [PTR_W-1:0] rd_ptr,
  input  logic [OFF_W-1:0] full_off,
  input  logic [OFF_W-1:0] empty_off,
  output logic             paf_n,
  output logic             pae_n
);

  logic [PTR_W-1:0] wr_ptr_r;
  logic [PTR_W-1:0] rd_ptr_w;
  logic             full_hit_w, empty_hit_w, async_w;
  logic             full_hit_r, empty_hit_r, async_r;

  ptf_ptr_xfer #(.PTR_W(PTR_W), .STAGES(SYNC_STAGES)) u_wr_xfer (
    .src_clk(wclk), .dst_clk(rclk), .rst_n(mrst_n),
    .src_ptr(wr_ptr), .dst_ptr(wr_ptr_r)
  );

  ptf_ptr_xfer #(.PTR_W(PTR_W), .STAGES(SYNC_STAGES)) u_rd_xfer (
    .src_clk(rclk), .dst_clk(wclk), .rst_n(mrst_n),
    .src_ptr(rd_ptr), .dst_ptr(rd_ptr_w)
  );

  ptf_side #(.DEPTH(DEPTH), .PTR_W(PTR_W), .OFF_W(OFF_W), .DEF_OFF(DEF_OFF),
             .WRITE_SIDE(1'b1)) u_wside (
    .clk(wclk), .rst_n(mrst_n), .async_cfg(async_cfg), .fwft_cfg(fwft_cfg),
    .own_ptr(wr_ptr), .far_ptr(rd_ptr_w),
    .full_off(full_off), .empty_off(empty_off),
    .full_hit(full_hit_w), .empty_hit(empty_hit_w), .async_q(async_w)
  );

  ptf_side #(.DEPTH(DEPTH), .PTR_W(PTR_W), .OFF_W(OFF_W), .DEF_OFF(DEF_OFF),
             .WRITE_SIDE(1'b0)) u_rside (
    .clk(rclk), .rst_n(mrst_n), .async_cfg(async_cfg), .fwft_cfg(fwft_cfg),
    .own_ptr(rd_ptr), .far_ptr(wr_ptr_r),
    .full_off(full_off), .empty_off(empty_off),
    .full_hit(full_hit_r), .empty_hit(empty_hit_r), .async_q(async_r)
  );

  // Almost full: set by the writer, released by the reader.
  ptf_flag_unit #(.RST_ASSERTED(1'b0), .STAGES(SYNC_STAGES)) u_paf (
    .set_clk(wclk), .clr_clk(rclk), .rst_n(mrst_n),
    .async_s(async_w), .async_c(async_r),
    .cond_s(full_hit_w), .cond_c(full_hit_r), .flag_n(paf_n)
  );

  // Almost empty: set by the reader, released by the writer.
  ptf_flag_unit #(.RST_ASSERTED(1'b1), .STAGES(SYNC_STAGES)) u_pae (
    .set_clk(rclk), .clr_clk(wclk), .rst_n(mrst_n),
    .async_s(async_r), .async_c(async_w),
    .cond_s(empty_hit_r), .cond_c(empty_hit_w), .flag_n(pae_n)
  );

endmodule

// File: rtl/ptf_flags_chk.sv
module ptf_flags_chk (
  input logic wclk,
  input logic rclk,
  input logic mrst_n,
  input logic paf_n,
  input logic pae_n,
  input logic full_hit_w,
  input logic full_hit_r,
  input logic empty_hit_w,
  input logic empty_hit_r,
  input logic async_w,
  input logic async_r
);

  AST_PAF_FALL_NEEDS_WRITER: assert property (@(posedge wclk) disable iff (!mrst_n)
    $fell(paf_n) |-> $past(full_hit_w)); // R6

  AST_PAE_FALL_NEEDS_READER: assert property (@(posedge rclk) disable iff (!mrst_n)
    $fell(pae_n) |-> $past(empty_hit_r)); // R7

  AST_PAF_RELEASE_BY_READER: assert property (@(posedge rclk) disable iff (!mrst_n)
    (async_r && $rose(paf_n)) |-> !$past(full_hit_r)); // R6

  AST_PAE_RELEASE_BY_WRITER: assert property (@(posedge wclk) disable iff (!mrst_n)
    (async_w && $rose(pae_n)) |-> !$past(empty_hit_w)); // R7

  AST_PAF_SYNC_FOLLOWS: assert property (@(posedge wclk) disable iff (!mrst_n)
    !async_w |-> (paf_n == !$past(full_hit_w))); // R8

  AST_PAE_SYNC_FOLLOWS: assert property (@(posedge rclk) disable iff (!mrst_n)
    !async_r |-> (pae_n == !$past(empty_hit_r))); // R9

  AST_MODE_HELD_W: assert property (@(posedge wclk) disable iff (!mrst_n)
    $stable(async_w)); // R10

  AST_MODE_HELD_R: assert property (@(posedge rclk) disable iff (!mrst_n)
    $stable(async_r)); // R10

endmodule

bind ptf_flags ptf_flags_chk u_chk (
  .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n),
  .paf_n(paf_n), .pae_n(pae_n),
  .full_hit_w(full_hit_w), .full_hit_r(full_hit_r),
  .empty_hit_w(empty_hit_w), .empty_hit_r(empty_hit_r),
  .async_w(async_w), .async_r(async_r)
);

// File: tb/tb_ptf_flags.sv
module tb_ptf_flags;
  localparam int CLK_PERIOD  = 10;
  localparam int RCLK_PERIOD = 14;
  localparam int DEPTH = 16;
  localparam int OFF_W = $clog2(DEPTH);
  localparam int PTR_W = $clog2(DEPTH + 1) + 1;

  logic wclk = 1'b0, rclk = 1'b0;
  logic mrst_n = 1'b0, async_cfg = 1'b0, fwft_cfg = 1'b0;
  logic [PTR_W-1:0] wr_ptr = '0, rd_ptr = '0;
  logic [OFF_W-1:0] full_off = OFF_W'(3), empty_off = OFF_W'(2);
  logic paf_n, pae_n;

  int tests = 0, fails = 0, level = 0;
  bit cur_fwft = 1'b0, done = 1'b0;

  always #(CLK_PERIOD/2) wclk = ~wclk;
  always #(RCLK_PERIOD/2) rclk = ~rclk;

  ptf_flags #(.DEPTH(DEPTH)) dut (
    .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n),
    .async_cfg(async_cfg), .fwft_cfg(fwft_cfg),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .full_off(full_off), .empty_off(empty_off),
    .paf_n(paf_n), .pae_n(pae_n)
  );

  function automatic bit exp_full(int lvl, int m, bit f);
    return lvl + m >= DEPTH + int'(f);
  endfunction

  function automatic bit exp_empty(int lvl, int n, bit f);
    return lvl - int'(f) <= n;
  endfunction

  task automatic check(string req, string what, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b (level %0d)", req, what, act, exp, level);
    end
  endtask

  task automatic write_one();
    @(negedge wclk); wr_ptr = wr_ptr + 1'b1; level++;
  endtask

  task automatic read_one();
    @(negedge rclk); rd_ptr = rd_ptr + 1'b1; level--;
  endtask

  task automatic burst_w(int k);
    for (int i = 0; i < k; i++) write_one();
  endtask

  task automatic burst_r(int k);
    for (int i = 0; i < k; i++) read_one();
  endtask

  task automatic fill_to(int target);
    while (level < target) write_one();
    while (level > target) read_one();
  endtask

  task automatic settle();
    repeat (6) @(posedge rclk);
    repeat (6) @(posedge wclk);
    #1;
  endtask

  task automatic check_settled(bit wrap);
    string rf, re;
    rf = cur_fwft ? "R3" : "R2";
    re = cur_fwft ? "R5" : "R4";
    if (wrap) begin rf = {rf, " R11"}; re = {re, " R11"}; end
    check(rf, "PAF level", paf_n, !exp_full(level, int'(full_off), cur_fwft));
    check(re, "PAE level", pae_n, !exp_empty(level, int'(empty_off), cur_fwft));
  endtask

  task automatic apply_reset(bit a, bit f);
    mrst_n = 1'b0; async_cfg = a; fwft_cfg = f;
    wr_ptr = '0; rd_ptr = '0; level = 0; cur_fwft = f;
    repeat (4) @(posedge rclk);
    #1;
    check("R1", "PAF in reset", paf_n, 1'b1);
    check("R1", "PAE in reset", pae_n, 1'b0);
    @(negedge wclk); mrst_n = 1'b1;
    repeat (3) @(posedge rclk);
    #1;
    check("R1", "PAF after reset", paf_n, 1'b1);
    check("R1", "PAE after reset", pae_n, 1'b0);
  endtask

  task automatic run_edges(bit a);
    string sf, se;
    int tf, te;
    sf = a ? "R6" : "R8";
    se = a ? "R7" : "R9";
    tf = DEPTH + int'(cur_fwft) - int'(full_off);
    te = int'(empty_off) + int'(cur_fwft);
    fill_to(tf - 1); settle(); check_settled(1'b0);
    write_one(); @(posedge wclk); #1;
    check(sf, "PAF set at next wclk edge", paf_n, 1'b0);
    settle(); check_settled(1'b0);
    read_one(); @(posedge rclk); #1;
    check(sf, "PAF after read at next rclk edge", paf_n, a ? 1'b1 : 1'b0);
    settle(); check_settled(1'b0);
    fill_to(te + 1); settle(); check_settled(1'b0);
    read_one(); @(posedge rclk); #1;
    check(se, "PAE set at next rclk edge", pae_n, 1'b0);
    settle(); check_settled(1'b0);
    write_one(); @(posedge wclk); #1;
    check(se, "PAE after write at next wclk edge", pae_n, a ? 1'b1 : 1'b0);
    settle(); check_settled(1'b0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    // Directed: each timing scheme in both modes.
    for (int k = 0; k < 4; k++) begin
      full_off = OFF_W'(3); empty_off = OFF_W'(2);
      apply_reset(k[0], k[1]);
      run_edges(k[0]);
    end

    // R10: mode inputs flipped after reset have no effect.
    full_off = OFF_W'(3); empty_off = OFF_W'(2);
    apply_reset(1'b1, 1'b0);
    async_cfg = 1'b0; fwft_cfg = 1'b1;
    fill_to(DEPTH - 3); settle();
    check("R10", "PAF uses captured standard threshold", paf_n, 1'b0);
    read_one(); @(posedge rclk); #1;
    check("R10", "PAF release keeps captured async timing", paf_n, 1'b1);
    settle();

    // Random concurrent bursts with wrapping counters.
    for (int k = 0; k < 4; k++) begin
      apply_reset(k[0], k[1]);
      for (int it = 0; it < 40; it++) begin
        int room, kw, kr;
        if ($urandom_range(0, 3) == 0) begin
          full_off  = OFF_W'($urandom_range(1, DEPTH - 2));
          empty_off = OFF_W'($urandom_range(0, DEPTH - 3));
        end
        room = DEPTH + int'(cur_fwft) - level;
        kw = $urandom_range(0, (room > 6) ? 6 : room);
        kr = $urandom_range(0, (level > 6) ? 6 : level);
        fork
          burst_w(kw);
          burst_r(kr);
        join
        settle();
        check_settled(1'b1);
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog R1..: run did not finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule